// File: doc/BRIEF.md
# Signed Integer to Single-Precision Float Converter

This block turns a 32-bit two's-complement integer into a binary32 floating-point word. A caller presents the integer, a 2-bit rounding selector and a valid strobe. Three register stages later the packed float, an inexact flag and a matching valid strobe come out. One new conversion can start every cycle.

The first stage finds the magnitude, its leading-zero count and the two special inputs. The second stage normalises the magnitude and collects the bits that are shifted out. The third stage applies the selected rounding and packs the sign, exponent and fraction. Zero and the most negative integer skip the datapath and produce fixed words. Because a 32-bit integer always fits the binary32 exponent range, no result can be denormal, infinite or NaN.

Top module: `int2flt_conv`

## Requirements
- R1: `res_valid_o` is high exactly three clock cycles after `in_valid_i` was high at a rising edge. The result and flag belong to the input taken at that edge.
- R2: An input of 0 gives result 0x00000000 with `inexact_o` low, in every rounding mode.
- R3: An input of 0x80000000 gives result 0xCF000000 with `inexact_o` low, in every rounding mode.
- R4: Result bit 31 equals input bit 31. A negative input is converted from its magnitude.
- R5: Result bits 30:23 equal 158 minus the leading-zero count of the magnitude, plus one when rounding carries out of the 24-bit significand. A magnitude below 2^24 converts exactly.
- R6: Mode 01 (toward zero) truncates the bits below the 24-bit significand.
- R7: Mode 10 (toward minus infinity) truncates positive values. For a negative inexact value it adds one to the significand.
- R8: Mode 11 (toward plus infinity) truncates negative values. For a positive inexact value it adds one to the significand.
- R9: Mode 00 (nearest, ties to even) rounds to the nearer representable value. On an exact tie it picks the value with an even significand.
- R10: When rounding carries the significand to 2^24, the fraction field becomes 0 and the exponent rises by one (0x7FFFFFFF in mode 00 gives 0x4F000000).
- R11: `inexact_o` is high exactly when the discarded bits of the magnitude are not all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| int_i | input | 32 | Two's-complement integer to convert |
| rmode_i | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| res_valid_o | output | 1 | Result valid |
| flt_o | output | 32 | binary32 result |
| inexact_o | output | 1 | Result differs from the integer |

## Verification
The bench builds the block with its default parameters: a 32-bit integer and an 8-bit exponent with a 23-bit fraction. With these values every shift amount from 0 to 31 can be reached. Random magnitudes of every bit length exercise each amount of discarded bits. Directed words cover exact ties, values just above and below a tie, and the all-ones significand that carries into the exponent. The two constant inputs are driven in all four modes.

// File: rtl/int2flt_pkg.sv
package int2flt_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_DOWN = 2'b10,
    RM_UP   = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    SP_NONE = 2'b00,
    SP_ZERO = 2'b01,
    SP_MIN  = 2'b10
  } spec_e;
endpackage

// File: rtl/int2flt_lzc.sv
module int2flt_lzc #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     data_i,
  output logic [CNT_W-1:0] cnt_o
);
  // priority encoder: highest set bit wins
  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (data_i[i]) cnt_o = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/int2flt_norm.sv
module int2flt_norm #(
  parameter int W     = 32,
  parameter int SIG_W = 24,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     mag_i,
  input  logic [CNT_W-1:0] lzc_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             guard_o,
  output logic             round_o,
  output logic             sticky_o
);
  localparam int LOW_W = W - SIG_W - 2;

  logic [W-1:0] shifted;

  assign shifted  = mag_i << lzc_i;
  assign sig_o    = shifted[W-1 -: SIG_W];
  assign guard_o  = shifted[W-SIG_W-1];
  assign round_o  = shifted[W-SIG_W-2];

  generate
    if (LOW_W > 0) begin : g_sticky
      assign sticky_o = |shifted[LOW_W-1:0];
    end else begin : g_no_sticky
      assign sticky_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/int2flt_round.sv
module int2flt_round
  import int2flt_pkg::*;
#(
  parameter int SIG_W = 24,
  parameter int EXP_W = 8,
  localparam int MAN_W = SIG_W - 1
) (
  input  rmode_e           mode_i,
  input  logic             sign_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic             guard_i,
  input  logic             round_i,
  input  logic             sticky_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [MAN_W-1:0] man_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             inexact_o
);
  logic           inc;
  logic [SIG_W:0] sum;
  logic           carry;

  assign inexact_o = guard_i | round_i | sticky_i;

  always_comb begin
    unique case (mode_i)
      RM_NEAR: inc = guard_i & (round_i | sticky_i | sig_i[0]);
      RM_ZERO: inc = 1'b0;
      RM_DOWN: inc = sign_i & inexact_o;
      RM_UP:   inc = ~sign_i & inexact_o;
      default: inc = 1'b0;
    endcase
  end

  assign sum   = {1'b0, sig_i} + (SIG_W+1)'(inc);
  assign carry = sum[SIG_W];
  assign man_o = carry ? sum[SIG_W-1:1] : sum[MAN_W-1:0];
  assign exp_o = exp_i + EXP_W'(carry);
endmodule

// File: rtl/int2flt_conv.sv
module int2flt_conv
  import int2flt_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic [INT_W-1:0]       int_i,
  input  logic [1:0]             rmode_i,
  output logic                   res_valid_o,
  output logic [EXP_W+MAN_W:0]   flt_o,
  output logic                   inexact_o
);
  localparam int SIG_W = MAN_W + 1;
  localparam int OUT_W = EXP_W + MAN_W + 1;
  localparam int CNT_W = $clog2(INT_W + 1);
  localparam int BIAS  = 2 ** (EXP_W - 1) - 1;
  localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(BIAS + INT_W - 1);
  localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] MIN_WORD = {1'b1, EXP_TOP, {MAN_W{1'b0}}};

  // stage 1: magnitude, lzc, specials
  logic             c1_sign;
  logic [INT_W-1:0] c1_mag;
  logic [CNT_W-1:0] c1_lzc;
  spec_e            c1_spec;

  assign c1_sign = int_i[INT_W-1];
  assign c1_mag  = c1_sign ? (~int_i + INT_W'(1)) : int_i;

  always_comb begin
    if (int_i == '0)          c1_spec = SP_ZERO;
    else if (int_i == INT_MIN) c1_spec = SP_MIN;
    else                      c1_spec = SP_NONE;
  end

  int2flt_lzc #(.W(INT_W), .CNT_W(CNT_W)) u_lzc (
    .data_i (c1_mag),
    .cnt_o  (c1_lzc)
  );

  logic             s1_valid, s1_sign;
  logic [INT_W-1:0] s1_mag;
  logic [CNT_W-1:0] s1_lzc;
  spec_e            s1_spec;
  rmode_e           s1_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_mag   <= '0;
      s1_lzc   <= '0;
      s1_spec  <= SP_NONE;
      s1_mode  <= RM_NEAR;
    end else begin
      s1_valid <= in_valid_i;
      if (in_valid_i) begin
        s1_sign <= c1_sign;
        s1_mag  <= c1_mag;
        s1_lzc  <= c1_lzc;
        s1_spec <= c1_spec;
        s1_mode <= rmode_e'(rmode_i);
      end
    end
  end

  // stage 2: normalise, collect guard/round/sticky
  logic [SIG_W-1:0] c2_sig;
  logic             c2_g, c2_r, c2_s;
  logic [EXP_W-1:0] c2_exp;

  int2flt_norm #(.W(INT_W), .SIG_W(SIG_W), .CNT_W(CNT_W)) u_norm (
    .mag_i    (s1_mag),
    .lzc_i    (s1_lzc),
    .sig_o    (c2_sig),
    .guard_o  (c2_g),
    .round_o  (c2_r),
    .sticky_o (c2_s)
  );

  assign c2_exp = EXP_TOP - EXP_W'(s1_lzc);

  logic             s2_valid, s2_sign, s2_g, s2_r, s2_s;
  logic [SIG_W-1:0] s2_sig;
  logic [EXP_W-1:0] s2_exp;
  spec_e            s2_spec;
  rmode_e           s2_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid <= 1'b0;
      s2_sign  <= 1'b0;
      s2_sig   <= '0;
      s2_g     <= 1'b0;
      s2_r     <= 1'b0;
      s2_s     <= 1'b0;
      s2_exp   <= '0;
      s2_spec  <= SP_NONE;
      s2_mode  <= RM_NEAR;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_sign <= s1_sign;
        s2_sig  <= c2_sig;
        s2_g    <= c2_g;
        s2_r    <= c2_r;
        s2_s    <= c2_s;
        s2_exp  <= c2_exp;
        s2_spec <= s1_spec;
        s2_mode <= s1_mode;
      end
    end
  end

  // normal path: leading one must sit at the top of the significand
  p_norm_msb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_valid && s2_spec == SP_NONE) |-> s2_sig[SIG_W-1]);

  // stage 3: round and pack
  logic [MAN_W-1:0] c3_man;
  logic [EXP_W-1:0] c3_exp;
  logic             c3_inx;

  int2flt_round #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_round (
    .mode_i    (s2_mode),
    .sign_i    (s2_sign),
    .sig_i     (s2_sig),
    .guard_i   (s2_g),
    .round_i   (s2_r),
    .sticky_i  (s2_s),
    .exp_i     (s2_exp),
    .man_o     (c3_man),
    .exp_o     (c3_exp),
    .inexact_o (c3_inx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      flt_o       <= '0;
      inexact_o   <= 1'b0;
    end else begin
      res_valid_o <= s2_valid;
      if (s2_valid) begin
        unique case (s2_spec)
          SP_ZERO: begin flt_o <= '0;       inexact_o <= 1'b0; end
          SP_MIN:  begin flt_o <= MIN_WORD; inexact_o <= 1'b0; end
          default: begin
            flt_o     <= {s2_sign, c3_exp, c3_man};
            inexact_o <= c3_inx;
          end
        endcase
      end
    end
  end

  p_sign_follow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> flt_o[OUT_W-1] == $past(int_i[INT_W-1], 3));

  p_valid_chain_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(s1_valid, 2));

  p_exp_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && flt_o != '0) |->
      (flt_o[OUT_W-2 -: EXP_W] >= EXP_W'(BIAS) && flt_o[OUT_W-2 -: EXP_W] <= EXP_TOP));

  p_zero_exact_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && flt_o == '0) |-> !inexact_o);
endmodule

// File: tb/int2flt_conv_tb.sv
module int2flt_conv_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] int_i = '0;
  logic [1:0]  rmode_i = '0;
  logic        res_valid_o;
  logic [31:0] flt_o;
  logic        inexact_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk_i = ~clk_i;

  int2flt_conv u_dut (
    .clk_i, .rst_ni, .in_valid_i, .int_i, .rmode_i,
    .res_valid_o, .flt_o, .inexact_o
  );

  // expectation pipe, depth 3
  bit          pv [3];
  logic [31:0] pr [3];
  bit          px [3];
  string       pt [3];

  function automatic void ref_conv(input logic [31:0] x, input logic [1:0] m,
                                   output logic [31:0] res, output bit inx);
    bit sgn;
    logic [63:0] mag, sig, rem, half;
    int p, sh, e;
    bit inc;
    inx = 0;
    if (x == 32'h0) begin res = 32'h0; return; end
    if (x == 32'h8000_0000) begin res = 32'hCF00_0000; return; end
    sgn = x[31];
    mag = sgn ? 64'(-$signed(x)) : 64'(x);
    p = 0;
    for (int i = 0; i < 32; i++) if (mag[i]) p = i;
    e = 127 + p;
    if (p <= 23) begin
      sig = mag << (23 - p);
      inc = 0;
    end else begin
      sh   = p - 23;
      sig  = mag >> sh;
      rem  = mag & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      inx  = rem != 0;
      case (m)
        2'b00:   inc = (rem > half) || (rem == half && sig[0]);
        2'b01:   inc = 0;
        2'b10:   inc = sgn && inx;
        default: inc = !sgn && inx;
      endcase
    end
    sig = sig + 64'(inc);
    if (sig == (64'd1 << 24)) begin sig = sig >> 1; e = e + 1; end
    res = {sgn, e[7:0], sig[22:0]};
  endfunction

  task automatic check_out();
    n_chk++;
    if (res_valid_o !== pv[2]) begin
      n_bad++;
      $display("FAIL R1 valid: got %0b exp %0b", res_valid_o, pv[2]);
    end else if (pv[2]) begin
      if (flt_o !== pr[2] || inexact_o !== px[2]) begin
        n_bad++;
        $display("FAIL %s: got %h/%0b exp %h/%0b", pt[2], flt_o, inexact_o, pr[2], px[2]);
      end
    end
  endtask

  task automatic step(input bit v, input logic [31:0] x, input logic [1:0] m, input string tag);
    logic [31:0] r;
    bit ix;
    @(negedge clk_i);
    check_out();
    for (int k = 2; k > 0; k--) begin
      pv[k] = pv[k-1]; pr[k] = pr[k-1]; px[k] = px[k-1]; pt[k] = pt[k-1];
    end
    ref_conv(x, m, r, ix);
    pv[0] = v; pr[0] = r; px[0] = ix; pt[0] = tag;
    in_valid_i = v; int_i = x; rmode_i = m;
  endtask

  function automatic string mode_tag(input logic [1:0] m, input logic [31:0] x);
    if (x == 0) return "R2";
    if (x == 32'h8000_0000) return "R3";
    case (m)
      2'b00:   return "R9";
      2'b01:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    logic [1:0]  m;
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int k = 0; k < 3; k++) begin pv[k] = 0; pr[k] = 0; px[k] = 0; pt[k] = "R1"; end
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (res_valid_o !== 1'b0 || flt_o !== 32'h0 || inexact_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got %0b %h %0b exp 0 0 0", res_valid_o, flt_o, inexact_o);
    end
    rst_ni = 1'b1;

    for (int mm = 0; mm < 4; mm++) begin
      step(1, 32'h0, 2'(mm), "R2");
      step(1, 32'h8000_0000, 2'(mm), "R3");
      step(1, 32'h7FFF_FFFF, 2'(mm), mm == 0 ? "R10" : "R6");
      step(1, 32'h8000_0001, 2'(mm), "R4");
      step(1, 32'h00FF_FFFF, 2'(mm), "R5");
      step(1, 32'hFF00_0001, 2'(mm), "R5");
      step(1, 32'h0100_0001, 2'(mm), "R11");
      step(1, 32'h0100_0003, 2'(mm), "R9");
      step(1, 32'h0300_0002, 2'(mm), "R9");
      step(1, 32'h0300_0006, 2'(mm), "R9");
      step(1, 32'hFCFF_FFFF, 2'(mm), "R8");
      step(1, 32'h01FF_FFFF, 2'(mm), "R10");
      step(1, 32'hFE00_0001, 2'(mm), "R7");
      step(1, 32'h1, 2'(mm), "R5");
      step(1, 32'hFFFF_FFFF, 2'(mm), "R4");
    end
    step(0, 32'h1234_5678, 2'b00, "R1");
    step(1, 32'h1234_5678, 2'b00, "R9");
    step(0, 32'h0, 2'b00, "R1");

    for (int n = 0; n < 3000; n++) begin
      x = $urandom();
      case ($urandom() % 4)
        0: x = x >> ($urandom() % 32);
        1: x = $signed(x) >>> ($urandom() % 32);
        2: x = {x[31:8], 8'h80} >> ($urandom() % 8);
        default: ;
      endcase
      m = 2'($urandom());
      step(($urandom() % 8) != 0, x, m, mode_tag(m, x));
    end
    repeat (4) step(0, 32'h0, 2'b00, "R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule